// File: doc/BRIEF.md
# Debug Cycle Profiling Counters

This block holds two 8-bit wrap-around profiling counters for a processor debug unit. The first, the instruction-overhead counter, counts two kinds of cycle. It counts every cycle an instruction spends beyond its first one, unless a separate load/store counter already claims that cycle. It also counts every instruction fetch stall cycle. The second, the exception-overhead counter, counts every cycle the core spends on exception entry stacking, return unstacking or pre-emption.

The core drives one qualifier strobe per cycle for each condition. Debug software starts a counter by raising its enable, which clears the counter to zero. Each counter can be read and loaded through a simple 32-bit register bus with byte addresses. When a counter wraps from 0xFF to 0x00, the block produces a one-cycle event pulse. A trace encoder downstream turns these pulses into packets.

Top module: `cycle_prof_ctr`

## Requirements
- R1: The instruction-overhead counter reads at byte offset 0x008 and the exception-overhead counter at 0x00C. The counter value sits in bits [7:0], bits [31:8] read as zero, and any other offset reads as all zeros.
- R2: While enabled, the instruction-overhead counter adds one in each cycle with `extra_cyc` high and `lsu_owned` low. An extra cycle with `lsu_owned` high is not counted.
- R3: While enabled, the instruction-overhead counter adds one in each `fetch_stall` cycle, whatever `lsu_owned` is. A cycle with both `fetch_stall` and a countable extra cycle adds exactly one.
- R4: While enabled, the exception-overhead counter adds one in each cycle with `exc_active` high.
- R5: In the cycle where a counter's enable goes from low to high, that counter is set to zero, and a count strobe in that same cycle is not added.
- R6: While its enable is low, a counter holds its value and its event output stays low.
- R7: A bus write to a counter's offset loads bits [7:0] of the write data. The write takes priority over both the enable-rise clear and the increment in the same cycle.
- R8: `cpi_evt` is high for exactly one cycle, the cycle in which the instruction-overhead counter first reads 0x00 after an increment from 0xFF. It does this only when `cpi_evt_en` is high.
- R9: `exc_evt` pulses for one cycle on every increment from 0xFF to 0x00 of the exception-overhead counter, which is once per 256 counted cycles.
- R10: A bus write that takes a counter from 0xFF to 0x00 produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpi_en | input | 1 | Instruction-overhead counter enable |
| cpi_evt_en | input | 1 | Allows the instruction-overhead wrap event |
| exc_en | input | 1 | Exception-overhead counter enable |
| extra_cyc | input | 1 | Instruction is in a cycle beyond its first |
| lsu_owned | input | 1 | Current extra cycle is claimed by the load/store counter |
| fetch_stall | input | 1 | Instruction fetch stalled this cycle |
| exc_active | input | 1 | Core is in exception entry, return or pre-emption |
| bus_addr | input | 12 | Byte address of register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| cpi_evt | output | 1 | Instruction-overhead wrap pulse |
| exc_evt | output | 1 | Exception-overhead wrap pulse |

## Verification
The embedded assertions check, on every cycle, that the reserved read bits stay zero, that events are single pulses seen only when the counter reads zero, that a disabled counter stays stable, that an enable rise clears the counter, and that a double strobe adds one. Some properties only the directed scenarios can show. These are the exact counts under mixed strobe patterns, that `lsu_owned` suppresses only extra cycles, that writes win over clear and increment, that events are gated by `cpi_evt_en`, and that a full 256-cycle run yields exactly one exception event.

// File: rtl/cycle_prof_ctr.sv
module cycle_prof_ctr #(
  parameter int          CW      = 8,
  parameter int          DW      = 32,
  parameter int          AW      = 12,
  parameter logic [11:0] CPI_OFS = 12'h008,
  parameter logic [11:0] EXC_OFS = 12'h00C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpi_en,
  input  logic          cpi_evt_en,
  input  logic          exc_en,
  input  logic          extra_cyc,
  input  logic          lsu_owned,
  input  logic          fetch_stall,
  input  logic          exc_active,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          cpi_evt,
  output logic          exc_evt
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cpi_cnt, exc_cnt;
  logic          cpi_en_q, exc_en_q;

  wire cpi_wr   = bus_wr && (bus_addr == AW'(CPI_OFS));
  wire exc_wr   = bus_wr && (bus_addr == AW'(EXC_OFS));
  wire cpi_rise = cpi_en && !cpi_en_q;
  wire exc_rise = exc_en && !exc_en_q;
  wire cpi_hit  = fetch_stall || (extra_cyc && !lsu_owned);
  wire cpi_inc  = cpi_en && !cpi_rise && !cpi_wr && cpi_hit;
  wire exc_inc  = exc_en && !exc_rise && !exc_wr && exc_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpi_en_q <= 1'b0;
      exc_en_q <= 1'b0;
    end else begin
      cpi_en_q <= cpi_en;
      exc_en_q <= exc_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpi_cnt <= '0;
      cpi_evt <= 1'b0;
    end else begin
      cpi_evt <= cpi_inc && cpi_evt_en && (cpi_cnt == TOP);
      if (cpi_wr)        cpi_cnt <= bus_wdata[CW-1:0];
      else if (cpi_rise) cpi_cnt <= '0;
      else if (cpi_inc)  cpi_cnt <= cpi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_cnt <= '0;
      exc_evt <= 1'b0;
    end else begin
      exc_evt <= exc_inc && (exc_cnt == TOP);
      if (exc_wr)        exc_cnt <= bus_wdata[CW-1:0];
      else if (exc_rise) exc_cnt <= '0;
      else if (exc_inc)  exc_cnt <= exc_cnt + 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(CPI_OFS))      bus_rdata[CW-1:0] = cpi_cnt;
    else if (bus_addr == AW'(EXC_OFS)) bus_rdata[CW-1:0] = exc_cnt;
  end

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:CW] == '0);

  a_r8_cpi_evt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cpi_evt |-> (cpi_cnt == '0));

  a_r8_cpi_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpi_evt |=> !cpi_evt);

  a_r9_exc_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    exc_evt |=> !exc_evt);

  a_r9_exc_evt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    exc_evt |-> (exc_cnt == '0));

  a_r6_cpi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpi_en && !cpi_wr) |=> ($stable(cpi_cnt) && !cpi_evt));

  a_r6_exc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_en && !exc_wr) |=> ($stable(exc_cnt) && !exc_evt));

  a_r5_cpi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cpi_en && !cpi_en_q && !cpi_wr) |=> (cpi_cnt == '0));

  a_r5_exc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && !exc_en_q && !exc_wr) |=> (exc_cnt == '0));

  a_r3_double_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cpi_en && cpi_en_q && !cpi_wr && fetch_stall && extra_cyc)
      |=> (cpi_cnt == $past(cpi_cnt) + 1'b1));

  a_r7_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    exc_wr |=> (exc_cnt == $past(bus_wdata[CW-1:0])));
endmodule

// File: tb/cycle_prof_ctr_bench.sv
module cycle_prof_ctr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpi_en = 1'b0, cpi_evt_en = 1'b0, exc_en = 1'b0;
  logic        extra_cyc = 1'b0, lsu_owned = 1'b0, fetch_stall = 1'b0, exc_active = 1'b0;
  logic [11:0] bus_addr = 12'h000;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpi_evt, exc_evt;
  int          n_chk = 0, n_fail = 0;

  localparam logic [11:0] A_CPI = 12'h008;
  localparam logic [11:0] A_EXC = 12'h00C;

  cycle_prof_ctr u_cycle_prof_ctr (
    .clk(clk), .rst_n(rst_n), .cpi_en(cpi_en), .cpi_evt_en(cpi_evt_en),
    .exc_en(exc_en), .extra_cyc(extra_cyc), .lsu_owned(lsu_owned),
    .fetch_stall(fetch_stall), .exc_active(exc_active), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpi_evt(cpi_evt), .exc_evt(exc_evt));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CPI, d); chk("R1 cpi reset", d, 0);
    rd(A_EXC, d); chk("R1 exc reset", d, 0);
    chk("R8 evt reset", {cpi_evt, exc_evt}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(A_CPI, 32'hABCDEF12);
    wr(A_EXC, 32'h55AA0034);
    rd(A_CPI, d); chk("R1 R7 cpi low byte", d, 32'h12);
    rd(A_EXC, d); chk("R1 R7 exc low byte", d, 32'h34);
    rd(12'h010, d); chk("R1 unmapped", d, 0);
  endtask

  task automatic t_cpi_count();
    logic [31:0] d;
    cpi_en = 1'b1; step(1);
    rd(A_CPI, d); chk("R5 enable clears", d, 0);
    extra_cyc = 1'b1; step(5); extra_cyc = 1'b0;
    rd(A_CPI, d); chk("R2 extra cycles", d, 5);
    extra_cyc = 1'b1; lsu_owned = 1'b1; step(3);
    rd(A_CPI, d); chk("R2 lsu suppresses", d, 5);
    extra_cyc = 1'b0; fetch_stall = 1'b1; step(2);
    rd(A_CPI, d); chk("R3 stall with lsu", d, 7);
    lsu_owned = 1'b0; extra_cyc = 1'b1; step(4);
    extra_cyc = 1'b0; fetch_stall = 1'b0;
    rd(A_CPI, d); chk("R3 both adds one", d, 11);
  endtask

  task automatic t_cpi_wrap();
    logic [31:0] d;
    cpi_evt_en = 1'b0;
    wr(A_CPI, 32'hFE);
    fetch_stall = 1'b1; step(1);
    chk("R8 no evt at FF", cpi_evt, 0);
    step(1); fetch_stall = 1'b0;
    rd(A_CPI, d); chk("R8 wrapped", d, 0);
    chk("R8 gated evt", cpi_evt, 0);
    cpi_evt_en = 1'b1;
    wr(A_CPI, 32'hFF);
    fetch_stall = 1'b1; step(1); fetch_stall = 1'b0;
    chk("R8 evt pulse", cpi_evt, 1);
    rd(A_CPI, d); chk("R8 zero with evt", d, 0);
    step(1);
    chk("R8 pulse ends", cpi_evt, 0);
  endtask

  task automatic t_write_prio();
    logic [31:0] d;
    extra_cyc = 1'b1;
    wr(A_CPI, 32'h40);
    extra_cyc = 1'b0;
    rd(A_CPI, d); chk("R7 write beats inc", d, 32'h40);
    wr(A_CPI, 32'hFF);
    fetch_stall = 1'b1;
    wr(A_CPI, 32'h00);
    fetch_stall = 1'b0;
    chk("R10 write wrap no evt", cpi_evt, 0);
    rd(A_CPI, d); chk("R10 write value", d, 0);
    cpi_en = 1'b0; step(1);
    cpi_en = 1'b1;
    wr(A_CPI, 32'h77);
    rd(A_CPI, d); chk("R7 write beats clear", d, 32'h77);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    int ev = 0;
    cpi_en = 1'b0;
    wr(A_CPI, 32'hFF);
    fetch_stall = 1'b1; extra_cyc = 1'b1;
    for (int i = 0; i < 5; i++) begin step(1); ev += cpi_evt; end
    fetch_stall = 1'b0; extra_cyc = 1'b0;
    rd(A_CPI, d); chk("R6 cpi held", d, 32'hFF);
    chk("R6 cpi no evt", ev, 0);
    wr(A_EXC, 32'hFF);
    exc_active = 1'b1; ev = 0;
    for (int i = 0; i < 4; i++) begin step(1); ev += exc_evt; end
    exc_active = 1'b0;
    rd(A_EXC, d); chk("R6 exc held", d, 32'hFF);
    chk("R6 exc no evt", ev, 0);
  endtask

  task automatic t_reenable();
    logic [31:0] d;
    cpi_en = 1'b1; fetch_stall = 1'b1; step(1);
    rd(A_CPI, d); chk("R5 rise ignores strobe", d, 0);
    step(1); fetch_stall = 1'b0;
    rd(A_CPI, d); chk("R5 counts after rise", d, 1);
  endtask

  task automatic t_exc();
    logic [31:0] d;
    int ev = 0;
    exc_en = 1'b1; exc_active = 1'b1; step(1);
    rd(A_EXC, d); chk("R5 exc rise clears", d, 0);
    for (int i = 0; i < 256; i++) begin step(1); ev += exc_evt; end
    exc_active = 1'b0;
    chk("R9 one evt per 256", ev, 1);
    rd(A_EXC, d); chk("R9 back to zero", d, 0);
    exc_active = 1'b1; step(10); exc_active = 1'b0;
    rd(A_EXC, d); chk("R4 exc count", d, 10);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_map();
    t_cpi_count();
    t_cpi_wrap();
    t_write_prio();
    t_disable();
    t_reenable();
    t_exc();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule